// File: doc/BRIEF.md
# Timer Clock-Enable Prescaler with Synchronized Release

This block produces per-cycle count-enable strobes for a set of synchronous timer/counters that all run on the system clock. A shared free-running 10-bit divider supplies divided ticks. An input pin per counter is synchronized and edge-detected. Each counter selects its own source with a 3-bit field: off, every cycle, one of four divided rates, or a falling or rising edge on its pin.

A small control register lets software freeze the counters and restart them together. Each of the two prescaler-reset bits normally acts as a one-shot: writing a one restarts that prescaler for one cycle. When the hold bit is set, the written reset values stay in place. The divider is then held at zero and every counter fed from an internal source stays quiet. Clearing the hold bit wipes both reset bits in one write, so all such counters restart on the same cycle. The reset bit for the asynchronous prescaler only leaves the block as a level, because that prescaler lives in another clock domain.

Top module: `tmr_prescaler`

## Requirements
- R1: Out of reset the control register reads 0x00.
- R2: Control register bits 6 to 2 always read as zero, and writes to them have no effect.
- R3: With the hold bit (bit 7) clear, a write that sets reset bit 0 (synchronous prescaler) or bit 1 (asynchronous prescaler) makes the bit read as one for the single cycle after the write. The bit reads zero after that.
- R4: With the hold bit set, both reset bits keep their last written values for as long as no further write occurs.
- R5: A write with bit 7 clear and bits 1:0 zero clears the hold bit and both reset bits in the same cycle.
- R6: Select 000 never produces an enable. Select 001 produces an enable on every cycle in which the synchronous prescaler reset is not asserted.
- R7: Selects 010, 011, 100 and 101 divide by 8, 64, 256 and 1024. The first cycle with the synchronous reset deasserted is cycle k=0, and an enable occurs in cycle k exactly when (k+1) is a multiple of the divisor.
- R8: While the synchronous reset bit is asserted, no counter on select 001 to 101 gets an enable. After release, all such counters resume on the same cycle, and no divided tick arrives before a full period has elapsed.
- R9: Select 110 (falling) or 111 (rising) gives exactly one one-cycle enable per matching pin edge. A pin change that arrives between clock edges n and n+1 shows up as an enable in the cycle that starts at edge n+2. These enables are never divided and never held off by a prescaler reset.
- R10: Changing the select to or from an external source while the pin has been stable for at least three cycles produces no enable.
- R11: The asynchronous prescaler reset output always equals control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| clk_sel | input | 3*NCNT | Per-counter source select, counter i at bits 3i+2:3i |
| ext_pin | input | NCNT | Per-counter external count pin |
| cnt_en | output | NCNT | Per-counter count-enable strobe |
| async_psc_rst | output | 1 | Reset level for the asynchronous prescaler |

## Verification
The hardest situation to reach is a long freeze followed by a synchronized release, with the slowest tap still phase-correct a thousand cycles later. Random register writes almost always cut the divider short before a divide-by-1024 tick can occur. The stimulus therefore includes a directed freeze of several counters on mixed internal sources, then a release and an uninterrupted run of more than two full 1024-cycle periods. Around that run, random traffic with rare register writes toggles the pins at no more than the allowed rate and changes the selects while edges are both in flight and absent.

// File: rtl/tpre_pkg.sv
package tpre_pkg;

    localparam int REG_W    = 8;
    localparam int HOLD_BIT = 7;
    localparam int ARST_BIT = 1;
    localparam int SRST_BIT = 0;
    localparam int SEL_W    = 3;
    localparam int NTAP     = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_PIN_FALL = 3'd6,
        SRC_PIN_RISE = 3'd7
    } src_sel_e;

    typedef struct packed {
        logic hold;
        logic arst;
        logic srst;
    } ctrl_t;

    // log2 of the divisor behind each divided tap
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tpre_ctrl.sv
module tpre_ctrl
    import tpre_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             srst,
    output logic             arst
);

    ctrl_t st_d, st_q;
    logic  unused_wbits;

    assign unused_wbits = ^wdata[HOLD_BIT-1:ARST_BIT+1];

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.hold = wdata[HOLD_BIT];
            st_d.arst = wdata[ARST_BIT];
            st_d.srst = wdata[SRST_BIT];
        end else if (!st_q.hold) begin
            // one-shot behaviour outside hold mode
            st_d.arst = 1'b0;
            st_d.srst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata           = '0;
        rdata[HOLD_BIT] = st_q.hold;
        rdata[ARST_BIT] = st_q.arst;
        rdata[SRST_BIT] = st_q.srst;
    end

    assign srst = st_q.srst;
    assign arst = st_q.arst;

endmodule

// File: rtl/tpre_divider.sv
module tpre_divider
    import tpre_pkg::*;
#(
    parameter int PSC_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [NTAP-1:0] tick
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.cnt = '0;
        else     st_d.cnt = st_q.cnt + PSC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        localparam int SH = tap_shift(t);
        // tick on the cycle whose successor wraps the low SH bits to zero
        assign tick[t] = !clr && (&st_q.cnt[SH-1:0]);
    end

endmodule

// File: rtl/tpre_edge.sv
module tpre_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], pin};
        st_d.prev  = st_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise =  st_q.chain[SYNC_STAGES-1] && !st_q.prev;
    assign fall = !st_q.chain[SYNC_STAGES-1] &&  st_q.prev;

endmodule

// File: rtl/tpre_srcsel.sv
module tpre_srcsel
    import tpre_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             srst,
    input  logic [NTAP-1:0]  tick,
    input  logic             rise,
    input  logic             fall,
    output logic             en
);

    always_comb begin
        case (src_sel_e'(sel))
            SRC_OFF:      en = 1'b0;
            SRC_SYS:      en = !srst;
            SRC_DIV8:     en = tick[0];
            SRC_DIV64:    en = tick[1];
            SRC_DIV256:   en = tick[2];
            SRC_DIV1024:  en = tick[3];
            SRC_PIN_FALL: en = fall;
            SRC_PIN_RISE: en = rise;
            default:      en = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tpre_pkg::*;
#(
    parameter int NCNT        = 2,
    parameter int PSC_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [SEL_W*NCNT-1:0] clk_sel,
    input  logic [NCNT-1:0]       ext_pin,
    output logic [NCNT-1:0]       cnt_en,
    output logic                  async_psc_rst
);

    logic            srst;
    logic [NTAP-1:0] tick;

    tpre_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .srst  (srst),
        .arst  (async_psc_rst)
    );

    tpre_divider #(.PSC_W(PSC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (srst),
        .tick  (tick)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        logic rise, fall;

        tpre_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[i]),
            .rise  (rise),
            .fall  (fall)
        );

        tpre_srcsel u_sel (
            .sel   (clk_sel[SEL_W*i +: SEL_W]),
            .srst  (srst),
            .tick  (tick),
            .rise  (rise),
            .fall  (fall),
            .en    (cnt_en[i])
        );
    end

endmodule

// File: rtl/tpre_chk.sv
module tpre_chk
    import tpre_pkg::*;
#(
    parameter int NCNT = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [REG_W-1:0]      reg_wdata,
    input logic [REG_W-1:0]      reg_rdata,
    input logic [SEL_W*NCNT-1:0] clk_sel,
    input logic [NCNT-1:0]       cnt_en,
    input logic                  async_psc_rst
);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[HOLD_BIT-1:ARST_BIT+1] == '0);

    // R3
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !reg_rdata[HOLD_BIT]) |=> (reg_rdata[ARST_BIT:SRST_BIT] == 2'b00));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && reg_rdata[HOLD_BIT]) |=> $stable(reg_rdata[ARST_BIT:SRST_BIT]));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[HOLD_BIT] == 1'b0 && reg_wdata[ARST_BIT:SRST_BIT] == 2'b00)
        |=> (reg_rdata[HOLD_BIT] == 1'b0 && reg_rdata[ARST_BIT:SRST_BIT] == 2'b00));

    // R11
    arst_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_psc_rst == reg_rdata[ARST_BIT]);

    for (genvar i = 0; i < NCNT; i++) begin : g_c
        logic [SEL_W-1:0] s;
        assign s = clk_sel[SEL_W*i +: SEL_W];

        // R6
        off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s == 3'd0) |-> !cnt_en[i]);

        // R8
        halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rdata[SRST_BIT] && s >= 3'd1 && s <= 3'd5) |-> !cnt_en[i]);
    end

endmodule

bind tmr_prescaler tpre_chk #(.NCNT(NCNT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .clk_sel       (clk_sel),
    .cnt_en        (cnt_en),
    .async_psc_rst (async_psc_rst)
);

// File: tb/tmr_prescaler_test.sv
`timescale 1ns/1ps
module tmr_prescaler_test;

    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [7:0]    reg_wdata;
    logic [7:0]    reg_rdata;
    logic [3*NC-1:0] clk_sel;
    logic [NC-1:0] ext_pin;
    logic [NC-1:0] cnt_en;
    logic          async_psc_rst;

    int nchk  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    tmr_prescaler #(.NCNT(NC)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .clk_sel       (clk_sel),
        .ext_pin       (ext_pin),
        .cnt_en        (cnt_en),
        .async_psc_rst (async_psc_rst)
    );

    // reference state, derived from the requirements
    logic          m_hold, m_ar, m_sr;
    logic [9:0]    m_k;                 // cycles since release (R7)
    logic [NC-1:0] h1, h2, h3;          // pin value one, two, three cycles back (R9)

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hold <= 1'b0; m_ar <= 1'b0; m_sr <= 1'b0;
            m_k <= '0; h1 <= '0; h2 <= '0; h3 <= '0;
        end else begin
            if (reg_wr) begin
                m_hold <= reg_wdata[7]; m_ar <= reg_wdata[1]; m_sr <= reg_wdata[0];
            end else if (!m_hold) begin
                m_ar <= 1'b0; m_sr <= 1'b0;
            end
            m_k <= m_sr ? 10'd0 : m_k + 10'd1;
            h1 <= ext_pin; h2 <= h1; h3 <= h2;
        end
    end

    function automatic int divisor(input logic [2:0] s);
        case (s)
            3'd2: return 8;
            3'd3: return 64;
            3'd4: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic logic exp_en(input int i);
        logic [2:0] s;
        s = clk_sel[3*i +: 3];
        case (s)
            3'd0: return 1'b0;
            3'd1: return !m_sr;
            3'd6: return !h2[i] && h3[i];
            3'd7: return h2[i] && !h3[i];
            default: return !m_sr && (((int'(m_k) + 1) % divisor(s)) == 0);
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0, 3'd1: return "R6 R8";
            3'd6, 3'd7: return "R9 R10";
            default:    return "R7 R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < NC; i++)
            chk(tag_of(clk_sel[3*i +: 3]), 32'(cnt_en[i]), 32'(exp_en(i)));
        chk("R2 R3 R4 R5 readback", 32'(reg_rdata), {24'd0, m_hold, 5'd0, m_ar, m_sr});
        chk("R11 async reset out", 32'(async_psc_rst), 32'(m_ar));
    endtask

    // one cycle: check outputs of the current cycle, then apply new inputs
    task automatic step(input logic wr, input logic [7:0] wd);
        @(negedge clk);
        check_all();
        reg_wr    = wr;
        reg_wdata = wd;
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) step(1'b0, 8'h00);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired: actual=running expected=done");
        finish_run();
    end

    int unsigned seed_init;
    int hold_cnt [NC];

    initial begin
        seed_init = $urandom(32'h00C0FFEE);
        rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        clk_sel = {3'd2, 3'd1}; ext_pin = '0;
        repeat (3) @(negedge clk);
        // R1: reset value
        chk("R1 reset readback", 32'(reg_rdata), 32'h0);
        rst_n = 1'b1;

        // R6 R7: sysclk and divide-by-8 free running
        idle(30);

        // R2: reserved bits ignored, hold bit set
        step(1'b1, 8'hFC);
        step(1'b0, 8'h00);
        chk("R2 reserved bits", 32'(reg_rdata), 32'h80);
        step(1'b1, 8'h00);
        idle(5);

        // R3: one-shot synchronous and asynchronous reset
        step(1'b1, 8'h01);
        step(1'b0, 8'h00);
        chk("R3 one-shot set", 32'(reg_rdata), 32'h01);
        idle(12);
        step(1'b1, 8'h02);
        idle(5);

        // R4 R8 R11: freeze with all internal sources halted
        clk_sel = {3'd3, 3'd1};
        step(1'b1, 8'h83);
        idle(40);
        chk("R4 held reset bits", 32'(reg_rdata), 32'h83);
        chk("R11 held async level", 32'(async_psc_rst), 32'h1);
        // R5: release everything together
        step(1'b1, 8'h00);
        step(1'b0, 8'h00);
        chk("R5 release", 32'(reg_rdata), 32'h00);
        idle(150);

        // R9: pin edges, fastest allowed toggling
        clk_sel = {3'd6, 3'd7};
        for (int j = 0; j < 10; j++) begin
            ext_pin = ~ext_pin;
            idle(3);
        end
        // R9: not held off by a frozen prescaler
        step(1'b1, 8'h81);
        for (int j = 0; j < 6; j++) begin
            ext_pin = ~ext_pin;
            idle(4);
        end
        step(1'b1, 8'h00);

        // R10: select changes on a stable pin
        ext_pin = 2'b11;
        idle(5);
        clk_sel = {3'd0, 3'd6}; idle(2);
        clk_sel = {3'd6, 3'd7}; idle(2);
        clk_sel = {3'd7, 3'd0}; idle(2);
        clk_sel = {3'd6, 3'd6}; idle(4);

        // R7 R8: long run for the two slowest taps after a synchronized release
        clk_sel = {3'd5, 3'd4};
        step(1'b1, 8'h81);
        idle(20);
        step(1'b1, 8'h00);
        idle(2200);

        // random traffic
        for (int i = 0; i < NC; i++) hold_cnt[i] = 3;
        for (int n = 0; n < 12000; n++) begin
            logic       w;
            logic [7:0] d;
            w = ($urandom % 160) == 0;
            d = 8'($urandom);
            if (($urandom % 90) == 0) clk_sel = 6'($urandom);
            for (int i = 0; i < NC; i++) begin
                if (hold_cnt[i] == 0) begin
                    ext_pin[i] = ~ext_pin[i];
                    hold_cnt[i] = 2 + int'($urandom % 5);
                end else begin
                    hold_cnt[i]--;
                end
            end
            step(w, d);
        end
        idle(4);
        finish_run();
    end

endmodule